// File: doc/BRIEF.md
# External Interrupt Exception Entry Unit

This unit decides when a pending external interrupt may be taken and, once it is, produces in one clock the whole processor state change that belongs to interrupt entry. It sees the merged external request (pin, timer or on-chip peripheral), a flag saying that an exception of higher priority is being taken now, the current machine state word, the address of the instruction that would run next, and two compression-control bits. On acceptance it registers the two save/restore words, the rewritten machine state word and the fetch target, and pulses a redirect strobe in that same cycle.

Two dispatch modes exist. In the plain mode every interrupt goes to a single entry at offset 0x500 from a base picked by the vector-location bit of the machine state. In the split mode a vector of up to `NSRC` source requests is examined. The pending source with the lowest index wins and gets its own entry 8 bytes apart from its neighbours. While it is being serviced, that source and every source with a higher index are masked in hardware, until a release pulse clears the stored level.

All bit names use big-endian numbering over a 32-bit word, so bit 0 is the MSB. The bit positions are: little-endian copy flag (ILE) 15, external enable (EE) 16, machine check enable (ME) 19, vector location (IP) 25, endian mode (LE) 31, and compression enable at `DCMPEN_BIT` (default 29).

Top module: `xint_entry`

## Requirements
- R1: A request is accepted only when machine state bit EE (big-endian bit 16) is 1 and `hp_busy` is 0 in the same cycle. A request that is refused stays pending for as long as the requester holds it.
- R2: On acceptance, `srr0` takes the value of `next_pc` from the accepting cycle.
- R3: On acceptance, `srr1` bits 0..15 (big-endian) become 0 and bits 16..31 are copied from the same bits of `msr_cur`.
- R4: On acceptance, `msr_new` keeps IP (bit 25) and ME (bit 19) from `msr_cur`, takes LE (bit 31) from the old ILE (bit 15), and clears every other bit, EE included.
- R5: On acceptance, the compression-enable bit of `msr_new` (big-endian bit `DCMPEN_BIT`, default 29) equals `comp_en AND comp_exc`.
- R6: With `split_mode` at 0, `fetch_addr` becomes base + 0x500, where base is 0xFFF00000 if IP of `msr_cur` is 1 and 0x00000000 if it is 0.
- R7: With `split_mode` at 1, the pending unmasked source with the lowest index i wins, and `fetch_addr` becomes base + 0x500 + 8*i.
- R8: After a split-mode acceptance of source i, sources with index i and above cannot be accepted, while sources below i still can, until `lvl_release` is pulsed in a cycle with no split-mode acceptance. An acceptance in the same cycle as a release wins, and it stores the new level.
- R9: `take` is a one-cycle pulse in the same cycle as the output update. No request is accepted in the cycle right after a pulse. The outputs hold their values whenever there is no acceptance.
- R10: While `rst_n` is low, every output is 0 and the stored mask level is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_mode | input | 1 | 1 selects per-source vectors with level masking |
| irq_req | input | 1 | Merged external interrupt request (plain mode) |
| src_req | input | NSRC | Per-source requests, index 0 highest priority (split mode) |
| hp_busy | input | 1 | A higher-priority exception is being taken this cycle |
| lvl_release | input | 1 | Clears the stored service level |
| msr_cur | input | 32 | Current machine state word |
| next_pc | input | 32 | Address of the instruction that would run next |
| comp_en | input | 1 | Compression enable control |
| comp_exc | input | 1 | Compression-on-exception control |
| take | output | 1 | Redirect strobe, one cycle per accepted interrupt |
| fetch_addr | output | 32 | Target fetch address |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 32 | Saved machine state bits |
| msr_new | output | 32 | Machine state word after entry |

## Verification
The bench builds the unit with its default parameters: 48 sources, 8-byte vector stride, and the compression bit at big-endian position 29. This lets it drive the lowest source and the highest, where the entry lands at offset 0x678. It also places the compression bit away from every kept bit, so a wrong pick of bit shows up in the rewritten state. Directed sequences cover nested masking, release racing an acceptance, and both vector bases. A long random phase then varies the enable, busy and compression inputs against the model.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int XLEN = 32;

    // big-endian machine-state bit numbers
    localparam int MSR_ILE_BE = 15;
    localparam int MSR_EE_BE  = 16;
    localparam int MSR_ME_BE  = 19;
    localparam int MSR_IP_BE  = 25;
    localparam int MSR_LE_BE  = 31;

    // convert a big-endian bit number to a vector index
    function automatic int le_pos(input int be_bit);
        return XLEN - 1 - be_bit;
    endfunction

    localparam int EE_L  = XLEN - 1 - MSR_EE_BE;
    localparam int ILE_L = XLEN - 1 - MSR_ILE_BE;
    localparam int ME_L  = XLEN - 1 - MSR_ME_BE;
    localparam int IP_L  = XLEN - 1 - MSR_IP_BE;
    localparam int LE_L  = XLEN - 1 - MSR_LE_BE;

    // saved-state copy region: big-endian bits 16..31 are the low half
    localparam logic [XLEN-1:0] SRR1_COPY_MASK = 32'h0000_FFFF;

endpackage

// File: rtl/xint_src_select.sv
module xint_src_select #(
    parameter int NSRC  = 48,
    parameter int SRC_W = 6
) (
    input  logic [NSRC-1:0]  src_req,
    input  logic             lvl_valid,
    input  logic [SRC_W-1:0] lvl_idx,
    output logic             any_eligible,
    output logic [SRC_W-1:0] win_idx
);

    logic [NSRC-1:0] eligible;

    // a source is eligible when requesting and not at or below the service level
    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        localparam logic [SRC_W-1:0] IDX = SRC_W'(g);
        assign eligible[g] = src_req[g] && !(lvl_valid && (IDX >= lvl_idx));
    end

    always_comb begin
        win_idx = '0;
        // scan from the top so that the lowest eligible index is left standing
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                win_idx = SRC_W'(i);
            end
        end
    end

    assign any_eligible = |eligible;

endmodule

// File: rtl/xint_state_rewrite.sv
module xint_state_rewrite
    import xint_pkg::*;
#(
    parameter int DCMPEN_BIT = 29
) (
    input  logic [XLEN-1:0] msr_cur,
    input  logic            comp_en,
    input  logic            comp_exc,
    output logic [XLEN-1:0] msr_next,
    output logic [XLEN-1:0] srr1_next
);

    localparam int DC_L = XLEN - 1 - DCMPEN_BIT;

    always_comb begin
        msr_next        = '0;
        msr_next[IP_L]  = msr_cur[IP_L];
        msr_next[ME_L]  = msr_cur[ME_L];
        msr_next[LE_L]  = msr_cur[ILE_L];
        msr_next[DC_L]  = comp_en & comp_exc;
    end

    assign srr1_next = msr_cur & SRR1_COPY_MASK;

endmodule

// File: rtl/xint_vector_gen.sv
module xint_vector_gen
    import xint_pkg::*;
#(
    parameter int              SRC_W       = 6,
    parameter logic [XLEN-1:0] HI_BASE     = 32'hFFF0_0000,
    parameter logic [XLEN-1:0] VEC_OFF     = 32'h0000_0500,
    parameter int              STRIDE_LOG2 = 3
) (
    input  logic             ip_high,
    input  logic             split_mode,
    input  logic [SRC_W-1:0] src_idx,
    output logic [XLEN-1:0]  target
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] slot;

    always_comb begin
        base = ip_high ? HI_BASE : '0;
        slot = split_mode ? (XLEN'(src_idx) << STRIDE_LOG2) : '0;
        target = base + VEC_OFF + slot;
    end

endmodule

// File: rtl/xint_entry.sv
module xint_entry
    import xint_pkg::*;
#(
    parameter int              NSRC        = 48,
    parameter int              DCMPEN_BIT  = 29,
    parameter logic [XLEN-1:0] HI_BASE     = 32'hFFF0_0000,
    parameter logic [XLEN-1:0] VEC_OFF     = 32'h0000_0500,
    parameter int              STRIDE_LOG2 = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            split_mode,
    input  logic            irq_req,
    input  logic [NSRC-1:0] src_req,
    input  logic            hp_busy,
    input  logic            lvl_release,
    input  logic [31:0]     msr_cur,
    input  logic [31:0]     next_pc,
    input  logic            comp_en,
    input  logic            comp_exc,
    output logic            take,
    output logic [31:0]     fetch_addr,
    output logic [31:0]     srr0,
    output logic [31:0]     srr1,
    output logic [31:0]     msr_new
);

    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] fetch;
        logic [XLEN-1:0] srr0;
        logic [XLEN-1:0] srr1;
        logic [XLEN-1:0] msr;
        logic            lvl_v;
        logic [SRC_W-1:0] lvl;
    } entry_state_t;

    entry_state_t st_d, st_q;

    logic             sel_any;
    logic [SRC_W-1:0] sel_idx;
    logic [XLEN-1:0]  msr_rw;
    logic [XLEN-1:0]  srr1_rw;
    logic [XLEN-1:0]  vec_addr;
    logic             pending;
    logic             accept;

    xint_src_select #(
        .NSRC  (NSRC),
        .SRC_W (SRC_W)
    ) u_sel (
        .src_req      (src_req),
        .lvl_valid    (st_q.lvl_v),
        .lvl_idx      (st_q.lvl),
        .any_eligible (sel_any),
        .win_idx      (sel_idx)
    );

    xint_state_rewrite #(
        .DCMPEN_BIT (DCMPEN_BIT)
    ) u_rw (
        .msr_cur   (msr_cur),
        .comp_en   (comp_en),
        .comp_exc  (comp_exc),
        .msr_next  (msr_rw),
        .srr1_next (srr1_rw)
    );

    xint_vector_gen #(
        .SRC_W       (SRC_W),
        .HI_BASE     (HI_BASE),
        .VEC_OFF     (VEC_OFF),
        .STRIDE_LOG2 (STRIDE_LOG2)
    ) u_vec (
        .ip_high    (msr_cur[IP_L]),
        .split_mode (split_mode),
        .src_idx    (sel_idx),
        .target     (vec_addr)
    );

    always_comb begin
        pending = split_mode ? sel_any : irq_req;
        accept  = pending && msr_cur[EE_L] && !hp_busy && !st_q.take;

        st_d      = st_q;
        st_d.take = 1'b0;

        if (accept) begin
            st_d.take  = 1'b1;
            st_d.fetch = vec_addr;
            st_d.srr0  = next_pc;
            st_d.srr1  = srr1_rw;
            st_d.msr   = msr_rw;
            if (split_mode) begin
                st_d.lvl_v = 1'b1;
                st_d.lvl   = sel_idx;
            end else if (lvl_release) begin
                st_d.lvl_v = 1'b0;
            end
        end else if (lvl_release) begin
            st_d.lvl_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take       = st_q.take;
    assign fetch_addr = st_q.fetch;
    assign srr0       = st_q.srr0;
    assign srr1       = st_q.srr1;
    assign msr_new    = st_q.msr;

endmodule

// File: rtl/xint_entry_chk.sv
module xint_entry_chk
    import xint_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        take,
    input logic        hp_busy,
    input logic [31:0] msr_cur,
    input logic [31:0] next_pc,
    input logic [31:0] fetch_addr,
    input logic [31:0] srr0,
    input logic [31:0] srr1,
    input logic [31:0] msr_new
);

    localparam logic [31:0] KEPT = (32'h1 << IP_L) | (32'h1 << ME_L);

    // R1
    ee_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(msr_cur[EE_L]));

    // R1
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !$past(hp_busy));

    // R2
    ret_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (srr0 == $past(next_pc)));

    // R3
    saved_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (srr1[31:16] == 16'h0));

    // R4
    kept_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (((msr_new ^ $past(msr_cur)) & KEPT) == 32'h0));

    // R4
    ee_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !msr_new[EE_L]);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take && $past(rst_n) |-> $stable(fetch_addr) && $stable(srr0) && $stable(msr_new));

    // R6
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (fetch_addr[2:0] == 3'b000));

endmodule

bind xint_entry xint_entry_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .hp_busy    (hp_busy),
    .msr_cur    (msr_cur),
    .next_pc    (next_pc),
    .fetch_addr (fetch_addr),
    .srr0       (srr0),
    .srr1       (srr1),
    .msr_new    (msr_new)
);

// File: tb/xint_entry_test.sv
`timescale 1ns/1ps
module xint_entry_test;

    localparam int NS = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          split_mode = 1'b0;
    logic          irq_req = 1'b0;
    logic [NS-1:0] src_req = '0;
    logic          hp_busy = 1'b0;
    logic          lvl_release = 1'b0;
    logic [31:0]   msr_cur = '0;
    logic [31:0]   next_pc = '0;
    logic          comp_en = 1'b0;
    logic          comp_exc = 1'b0;
    logic          take;
    logic [31:0]   fetch_addr, srr0, srr1, msr_new;

    int checks = 0;
    int fails = 0;

    // reference model state
    bit        m_take;
    bit [31:0] m_fetch, m_srr0, m_srr1, m_msr;
    bit        m_lv;
    int        m_lvl;

    always #4 clk = ~clk;

    xint_entry uut (
        .clk (clk), .rst_n (rst_n), .split_mode (split_mode), .irq_req (irq_req),
        .src_req (src_req), .hp_busy (hp_busy), .lvl_release (lvl_release),
        .msr_cur (msr_cur), .next_pc (next_pc), .comp_en (comp_en), .comp_exc (comp_exc),
        .take (take), .fetch_addr (fetch_addr), .srr0 (srr0), .srr1 (srr1), .msr_new (msr_new)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // big-endian bit b of a word
    function automatic bit bebit(input bit [31:0] w, input int b);
        return w[31 - b];
    endfunction

    task automatic model_step();
        int  w;
        bit  pend, acc;
        bit [31:0] nm;
        w = -1;
        if (split_mode) begin
            for (int i = 0; i < NS; i++) begin
                if (w < 0 && src_req[i] && !(m_lv && i >= m_lvl)) w = i;
            end
        end
        pend = split_mode ? (w >= 0) : irq_req;
        acc  = pend && bebit(msr_cur, 16) && !hp_busy && !m_take;
        m_take = acc;
        if (acc) begin
            m_srr0 = next_pc;
            m_srr1 = {16'h0, msr_cur[15:0]};
            nm = '0;
            nm[31-25] = bebit(msr_cur, 25);
            nm[31-19] = bebit(msr_cur, 19);
            nm[31-31] = bebit(msr_cur, 15);
            nm[31-29] = comp_en & comp_exc;
            m_msr = nm;
            m_fetch = (bebit(msr_cur, 25) ? 32'hFFF0_0000 : 32'h0) + 32'h500
                      + (split_mode ? 32'(w * 8) : 32'h0);
            if (split_mode) begin
                m_lv = 1'b1;
                m_lvl = w;
            end else if (lvl_release) begin
                m_lv = 1'b0;
            end
        end else if (lvl_release) begin
            m_lv = 1'b0;
        end
    endtask

    // inputs already set at a falling edge; advance one cycle and compare
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R1 R8 R9 take", {31'h0, take}, {31'h0, m_take});
        chk("R2 srr0", srr0, m_srr0);
        chk("R3 srr1", srr1, m_srr1);
        chk("R4 msr_new kept/cleared", msr_new & ~32'h4, m_msr & ~32'h4);
        chk("R5 msr_new compression bit", {31'h0, msr_new[2]}, {31'h0, m_msr[2]});
        chk(split_mode ? "R7 R8 fetch_addr" : "R6 fetch_addr", fetch_addr, m_fetch);
    endtask

    // msr with EE, ILE, ME, IP chosen; other bits noisy
    function automatic bit [31:0] mk_msr(input bit ee, input bit ile, input bit me,
                                         input bit ip, input bit [31:0] noise);
        bit [31:0] v;
        v = noise;
        v[31-16] = ee;
        v[31-15] = ile;
        v[31-19] = me;
        v[31-25] = ip;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 take reset", {31'h0, take}, 32'h0);
        chk("R10 fetch reset", fetch_addr, 32'h0);
        chk("R10 srr0 reset", srr0, 32'h0);
        chk("R10 srr1 reset", srr1, 32'h0);
        chk("R10 msr reset", msr_new, 32'h0);
        m_take = 0; m_fetch = 0; m_srr0 = 0; m_srr1 = 0; m_msr = 0; m_lv = 0; m_lvl = 0;
        rst_n = 1'b1;

        // R1: EE clear holds the request off
        irq_req = 1'b1;
        msr_cur = mk_msr(0, 1, 1, 1, 32'hA5A5_5A5A);
        next_pc = 32'h0000_1234;
        repeat (3) cyc();
        // R1: busy flag holds it off
        msr_cur = mk_msr(1, 1, 1, 1, 32'hA5A5_5A5A);
        hp_busy = 1'b1;
        repeat (2) cyc();
        // R1 R6: accepted, high base; R9: blocked next cycle, then retaken
        hp_busy = 1'b0;
        comp_en = 1'b1; comp_exc = 1'b1;
        cyc();
        next_pc = 32'h0000_2000;
        cyc();
        cyc();
        irq_req = 1'b0;
        repeat (2) cyc();

        // R4 R5 R6: low base, ILE 0, compression off
        msr_cur = mk_msr(1, 0, 0, 0, 32'h3C3C_C3C3);
        comp_en = 1'b1; comp_exc = 1'b0;
        next_pc = 32'h0040_0008;
        irq_req = 1'b1;
        cyc();
        irq_req = 1'b0;
        cyc();

        // R7 R8: split mode with sources 5, 20, 47
        split_mode = 1'b1;
        msr_cur = mk_msr(1, 1, 0, 0, 32'h0F0F_0F0F);
        src_req = '0;
        src_req[5] = 1'b1; src_req[20] = 1'b1; src_req[47] = 1'b1;
        next_pc = 32'h0000_3000;
        cyc();
        repeat (3) cyc();            // R8: 20 and 47 masked behind level 5
        src_req[3] = 1'b1;           // R8: lower source still accepted
        cyc();
        cyc();
        src_req[3] = 1'b0; src_req[5] = 1'b0;
        repeat (2) cyc();            // R8: level now 3, 20 still masked
        lvl_release = 1'b1;          // release, then 20 wins
        cyc();
        lvl_release = 1'b0;
        repeat (2) cyc();
        src_req[20] = 1'b0;
        lvl_release = 1'b1;          // R7: highest index alone, high base
        msr_cur = mk_msr(1, 0, 1, 1, 32'h1234_5678);
        cyc();
        lvl_release = 1'b0;
        repeat (2) cyc();
        // R8: release racing an acceptance keeps the new level
        src_req = '0;
        src_req[10] = 1'b1; src_req[30] = 1'b1;
        lvl_release = 1'b1;
        cyc();
        lvl_release = 1'b0;
        src_req[10] = 1'b0;
        repeat (3) cyc();
        lvl_release = 1'b1;
        cyc();
        lvl_release = 1'b0;
        src_req = '0;
        cyc();

        // random phase over every input
        for (int n = 0; n < 1500; n++) begin
            split_mode  = ($urandom % 3) == 0;
            irq_req     = ($urandom % 2) == 0;
            src_req     = {16'($urandom), 32'($urandom)} & {16'($urandom), 32'($urandom)};
            hp_busy     = ($urandom % 4) == 0;
            lvl_release = ($urandom % 5) == 0;
            msr_cur     = $urandom;
            next_pc     = $urandom & 32'hFFFF_FFFC;
            comp_en     = $urandom % 2;
            comp_exc    = $urandom % 2;
            cyc();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule